// File: doc/BRIEF.md
# DMA Interrupt Control Word

This block holds the single 32-bit control and status word that governs interrupts raised by a set of DMA channels. Software writes the word to configure a few general-purpose low bits, a per-channel enable mask, a master enable and a force bit. Each channel reports the end of a transfer with a one-cycle done strobe. A done strobe latches a sticky per-channel flag, and software acknowledges that flag by writing a one to it.

The top bit is not writable. It is recomputed from the rest of the word whenever the word can change, and it shows whether an interrupt is being requested. When that bit goes from clear to set, the block emits a one-cycle pulse towards the system interrupt controller. A steady request therefore yields exactly one pulse. A new pulse needs the bit to drop and rise again.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset, the control word reads 0x00000000 and the interrupt pulse is low.
- R2: A write loads bits 5:0 (general purpose), bit 15 (force), bits 22:16 (channel enables, bit 16+n for channel n) and bit 23 (master enable) from the written data. Bits 14:6 always read zero.
- R3: On a write, a flag bit 24+n is cleared when written data bit 24+n is 1, and keeps its value when that bit is 0.
- R4: A done strobe on channel n sets flag bit 24+n when enable bit 16+n is set. The enable value used is the one in force after a write in the same cycle.
- R5: A done strobe on a channel whose enable bit is clear leaves its flag unchanged.
- R6: Bit 31 equals (bit 23 AND any of bits 30:24) OR bit 15. It is re-evaluated after every write and every done strobe, and it clears when that condition becomes false.
- R7: irq_pulse_o is high for exactly the one cycle in which bit 31 changes from 0 to 1. It stays low while bit 31 remains set.
- R8: When a write clears a flag and a done strobe sets the same flag in the same cycle, the flag ends up set.
- R9: Written data bit 31 has no effect on bit 31 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Data written to the control word |
| ch_done_i | input | NUM_CH | One-cycle transfer-done strobes, one per channel |
| ctl_o | output | 32 | Current control word |
| irq_pulse_o | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench builds the block with its default of seven channels and six general-purpose bits. With these values, every flag position 24 to 30 and every enable position 16 to 22 is populated. The clear mask, the enable gating and the master-enable term can then be exercised on real channels, including the highest one. At this width the word has no unused flag positions, so the derived top bit sits directly above the last flag. The sequence covers requests that stay asserted, drop and rise again, and are produced by the force bit alone. It also covers a clear and a done strobe colliding in the same cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned FORCE_BIT  = 15;
  localparam int unsigned EN_LSB     = 16;
  localparam int unsigned MASTER_BIT = 23;
  localparam int unsigned FLAG_LSB   = 24;
  localparam int unsigned SENT_BIT   = 31;
  localparam int unsigned MAX_CH     = 7;
endpackage

// File: rtl/dma_irq_flag_bank.sv
// Next-state logic of the sticky per-channel completion flags.
module dma_irq_flag_bank #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic [NUM_CH-1:0] flag_q_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] flag_d_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // set beats clear when both land in the same cycle
    assign flag_d_o[n] = (flag_q_i[n] & ~clr_i[n]) | (done_i[n] & en_i[n]);
  end
endmodule

// File: rtl/dma_irq_eval.sv
// Request condition and rising-edge pulse generation.
module dma_irq_eval #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              master_i,
  input  logic              force_i,
  input  logic [NUM_CH-1:0] flag_i,
  input  logic              sent_q_i,
  output logic              sent_d_o,
  output logic              pulse_d_o
);
  logic any_flag;

  always_comb begin
    any_flag  = |flag_i;
    sent_d_o  = (master_i & any_flag) | force_i;
    pulse_d_o = sent_d_o & ~sent_q_i;
  end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned MISC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NUM_CH-1:0] ch_done_i,
  output logic [31:0]       ctl_o,
  output logic              irq_pulse_o
);
  localparam int unsigned CH_USED = (NUM_CH < MAX_CH) ? NUM_CH : MAX_CH;

  logic [MISC_W-1:0] misc_q, misc_d;
  logic              force_q, force_d;
  logic [NUM_CH-1:0] chen_q, chen_d;
  logic              master_q, master_d;
  logic [NUM_CH-1:0] flag_q, flag_d;
  logic [NUM_CH-1:0] clr_mask;
  logic              sent_q, sent_d;
  logic              pulse_q, pulse_d;
  logic              upd_en;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i;

  // next state of the software-written fields
  always_comb begin
    if (wr_en_i) begin
      misc_d   = wr_data_i[MISC_W-1:0];
      force_d  = wr_data_i[FORCE_BIT];
      chen_d   = wr_data_i[EN_LSB +: NUM_CH];
      master_d = wr_data_i[MASTER_BIT];
      clr_mask = wr_data_i[FLAG_LSB +: NUM_CH];
    end else begin
      misc_d   = misc_q;
      force_d  = force_q;
      chen_d   = chen_q;
      master_d = master_q;
      clr_mask = '0;
    end
    upd_en = wr_en_i | (|ch_done_i);
  end

  dma_irq_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .flag_q_i (flag_q),
    .clr_i    (clr_mask),
    .done_i   (ch_done_i),
    .en_i     (chen_d),
    .flag_d_o (flag_d)
  );

  dma_irq_eval #(.NUM_CH(NUM_CH)) u_eval (
    .master_i  (master_d),
    .force_i   (force_d),
    .flag_i    (flag_d),
    .sent_q_i  (sent_q),
    .sent_d_o  (sent_d),
    .pulse_d_o (pulse_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q   <= '0;
      force_q  <= 1'b0;
      chen_q   <= '0;
      master_q <= 1'b0;
      flag_q   <= '0;
      sent_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (upd_en) begin
        misc_q   <= misc_d;
        force_q  <= force_d;
        chen_q   <= chen_d;
        master_q <= master_d;
        flag_q   <= flag_d;
        sent_q   <= sent_d;
      end
      pulse_q <= upd_en & pulse_d;
    end
  end

  // output word assembly
  always_comb begin
    ctl_o                         = '0;
    ctl_o[MISC_W-1:0]             = misc_q;
    ctl_o[FORCE_BIT]              = force_q;
    ctl_o[EN_LSB +: CH_USED]      = chen_q[CH_USED-1:0];
    ctl_o[MASTER_BIT]             = master_q;
    ctl_o[FLAG_LSB +: CH_USED]    = flag_q[CH_USED-1:0];
    ctl_o[SENT_BIT]               = sent_q;
  end

  assign irq_pulse_o = pulse_q;
endmodule

// File: rtl/dma_irq_ctl_chk.sv
module dma_irq_ctl_chk #(
  parameter int unsigned NUM_CH = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [NUM_CH-1:0] ch_done_i,
  input logic [31:0]       ctl_o,
  input logic              irq_pulse_o
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[14:6] == 9'd0);

  assert_sent_formula_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[31] == ((ctl_o[23] && (|ctl_o[30:24])) || ctl_o[15]));

  assert_pulse_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse_o |-> (ctl_o[31] && !$past(ctl_o[31])));

  assert_rise_gives_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o[31]) |-> irq_pulse_o);

  assert_quiet_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && ch_done_i == '0) |=> $stable(ctl_o));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && ch_done_i[n] && ctl_o[16+n]) |=> ctl_o[24+n]);
    assert_done_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && ch_done_i[n] && !ctl_o[16+n]) |=> $stable(ctl_o[24+n]));
  end
endmodule

bind dma_irq_ctl dma_irq_ctl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en_i     (wr_en_i),
  .ch_done_i   (ch_done_i),
  .ctl_o       (ctl_o),
  .irq_pulse_o (irq_pulse_o)
);

// File: tb/dma_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_ctl_tb_top;
  localparam int NUM_CH = 7;

  typedef struct {
    logic [31:0] ctl;
    logic        pulse;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic [NUM_CH-1:0] done = '0;
  logic [31:0]       ctl;
  logic              pulse;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic [31:0] m_word = '0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  dma_irq_ctl #(.NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ch_done_i(done), .ctl_o(ctl), .irq_pulse_o(pulse)
  );

  // one cycle of stimulus; model computes the expected word
  task automatic step(input logic w, input logic [31:0] d,
                      input logic [NUM_CH-1:0] dn, input string tag);
    logic [31:0] cfg;
    logic [6:0]  fl;
    logic        cond;
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_data = d; done = dn;
    cfg = (w ? d : m_word) & 32'h00FF_803F;
    fl = m_word[30:24];
    if (w) fl = fl & ~d[30:24];
    fl = fl | (dn & cfg[22:16]);
    cond = (cfg[23] && (fl != 0)) || cfg[15];
    e.pulse = cond && !m_word[31];
    m_word = cfg | {1'b0, fl, 24'd0} | {cond, 31'd0};
    e.ctl = m_word;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares one expected item per clock, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (ctl !== e.ctl || pulse !== e.pulse) begin
          errors++;
          $display("FAIL %s ctl=%h pulse=%b expected ctl=%h pulse=%b",
                   e.tag, ctl, pulse, e.ctl, e.pulse);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (ctl !== 32'h0 || pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 ctl=%h pulse=%b expected ctl=00000000 pulse=0", ctl, pulse);
    end
    rst_n = 1'b1;
    step(0, 32'h0, 7'h00, "R1");
    step(1, 32'h0000_002A, 7'h00, "R2");
    step(1, 32'h0000_7FC0, 7'h00, "R2");
    step(1, 32'h007F_0000, 7'h00, "R2");
    step(0, 32'h0, 7'h01, "R4");
    step(0, 32'h0, 7'h00, "R6");
    step(1, 32'h00FF_0000, 7'h00, "R6");
    step(0, 32'h0, 7'h00, "R7");
    step(0, 32'h0, 7'h02, "R7");
    step(1, 32'h01FF_0000, 7'h00, "R3");
    step(1, 32'h02FF_0000, 7'h00, "R6");
    step(0, 32'h0, 7'h04, "R7");
    step(1, 32'h0080_0000, 7'h00, "R5");
    step(0, 32'h0, 7'h08, "R5");
    step(0, 32'h0, 7'h40, "R5");
    step(1, 32'h7F80_0000, 7'h00, "R3");
    step(1, 32'h8080_0000, 7'h00, "R9");
    step(1, 32'h0080_8000, 7'h00, "R6");
    step(1, 32'h0080_0000, 7'h00, "R6");
    step(1, 32'h00FF_0000, 7'h00, "R2");
    step(1, 32'h10FF_0000, 7'h10, "R8");
    step(1, 32'h0020_0000, 7'h20, "R4");
    step(0, 32'h0, 7'h40, "R5");
    step(1, 32'h00C0_0000, 7'h40, "R4");
    step(0, 32'h0, 7'h00, "R7");
    @(negedge clk);
    wr_en = 0; done = '0;
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule